// File: doc/BRIEF.md
# Supply Power-Fail Access Guard

This block supervises the main supply of a battery-backed memory-and-clock macro. Two comparator flags arrive from the analog front end. One reports that the supply has dropped under the power-fail trip point. The other reports that the supply has dropped under the backup cell voltage. From these flags the guard decides three things: whether bus accesses to the clock and RAM are allowed, whether the reset request is pulled low, and which source powers the retained logic.

When the supply fails, the guard blocks accesses in the same cycle, so a write that is under way is cut short and is not completed. The reset request is pulled low at the same moment. After the supply comes back, the reset request stays low for a fixed recovery time, which is counted in ticks of a slow system timebase. The backup cell is kept off until the supply first rises above the trip point. From then on the cell is armed, and the retained logic moves to it once the supply falls below the lower of the two thresholds. A test-mode input can disarm the cell again.

Top module: `supply_guard`

## Requirements
- R1: `access_block_o` is 1 in every cycle in which `below_pf_i` is 1 and is 0 otherwise, with no register delay and no recovery extension.
- R2: `rst_drive_low_o` (1 = drive the open-drain reset low, 0 = release) is 1 in the same cycle that `below_pf_i` rises and stays 1 while `below_pf_i` is 1.
- R3: Once `below_pf_i` is 0, `rst_drive_low_o` is released right after the clock edge that samples the HOLD_TICKS-th `tick_i` pulse with `below_pf_i` at 0. HOLD_TICKS = ceil(TICK_HZ*RECOVERY_MS/1000), which is 1147 for the defaults 32768 and 35.
- R4: If `below_pf_i` returns to 1 during the recovery delay, the tick count restarts from zero. A full HOLD_TICKS of good ticks is then needed again.
- R5: Clock edges that have `tick_i` at 0 do not advance the recovery delay, so the reset stays held for as long as no tick pulses arrive.
- R6: After `rst_n` is asserted, `rst_drive_low_o` is 1, `bat_armed_o` is 0 and `src_backup_o` is 0.
- R7: `bat_armed_o` becomes 1 after the first clock edge at which `below_pf_i` is 0. It then stays 1 through any later supply failures.
- R8: `src_backup_o` (1 = backup cell, 0 = main supply) is 1 only when the cell is armed and both `below_pf_i` and `below_bat_i` are 1. This means switch-over happens at the lower of the two thresholds. The output follows the flags in the same cycle.
- R9: A clock edge with `test_clr_i` at 1 clears `bat_armed_o`. The clear takes priority over arming in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset of the guard state |
| below_pf_i | input | 1 | Supply is below the power-fail trip point |
| below_bat_i | input | 1 | Supply is below the backup cell voltage |
| tick_i | input | 1 | One-cycle timebase pulse at TICK_HZ |
| test_clr_i | input | 1 | Test-mode clear of the battery arm latch |
| access_block_o | output | 1 | Inhibits clock and RAM accesses |
| rst_drive_low_o | output | 1 | 1 pulls the open-drain reset low |
| src_backup_o | output | 1 | 1 selects the backup cell as power source |
| bat_armed_o | output | 1 | One-time battery connect latch state |

## Verification
The access inhibit, the reset assertion and the source select are combinational from the flags. They are due in the same cycle as the stimulus, so the bench drives on the falling edge and checks one time unit later. The arm latch and its clear take effect at the next rising edge, and the bench samples them just after that edge. The reset release is due exactly at the HOLD_TICKS-th qualifying tick edge. The bench checks the reset one edge before that point, where it must still be held, and again at that edge, where it must be released. This is done from a fresh return of the supply, after a dip partway through recovery, and after a long stretch with no ticks.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;

    localparam int unsigned MS_PER_S = 1000;

    typedef enum logic {
        SRC_MAIN   = 1'b0,
        SRC_BACKUP = 1'b1
    } src_e;

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/sg_recovery_timer.sv
module sg_recovery_timer #(
    parameter int unsigned HOLD_TICKS = 1147
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_low_i,
    input  logic tick_i,
    output logic hold_o
);
    localparam int unsigned CNT_W = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_TICKS - 1);

    typedef struct packed {
        logic             hold;
        logic [CNT_W-1:0] cnt;
    } recov_t;

    recov_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (supply_low_i) begin
            st_d.hold = 1'b1;
            st_d.cnt  = '0;
        end else if (st_q.hold && tick_i) begin
            if (st_q.cnt == LAST) begin
                st_d.hold = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt  = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hold <= 1'b1;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_o = st_q.hold;

    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);

    a_r3_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.hold) |-> ($past(tick_i) && !$past(supply_low_i)));

    a_r4_dip_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low_i |=> (st_q.hold && st_q.cnt == '0));

    a_r5_no_tick_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hold && !tick_i && !supply_low_i) |=> (st_q.hold && $stable(st_q.cnt)));

endmodule

// File: rtl/sg_backup_latch.sv
module sg_backup_latch
    import supply_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic supply_low_i,
    input  logic below_bat_i,
    input  logic test_clr_i,
    output logic armed_o,
    output logic src_o
);
    typedef struct packed {
        logic armed;
    } arm_t;

    arm_t st_d, st_q;
    src_e sel;

    always_comb begin
        st_d = st_q;
        if (test_clr_i) begin
            st_d.armed = 1'b0;
        end else if (!supply_low_i) begin
            st_d.armed = 1'b1;
        end
    end

    always_comb begin
        sel = SRC_MAIN;
        if (st_q.armed && supply_low_i && below_bat_i) begin
            sel = SRC_BACKUP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.armed <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed_o = st_q.armed;
    assign src_o   = (sel == SRC_BACKUP);

    a_r7_armed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && !test_clr_i) |=> st_q.armed);

    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        test_clr_i |=> !st_q.armed);

endmodule

// File: rtl/supply_guard.sv
module supply_guard
    import supply_guard_pkg::*;
#(
    parameter int unsigned TICK_HZ     = 32768,
    parameter int unsigned RECOVERY_MS = 35
) (
    input  logic clk,
    input  logic rst_n,
    input  logic below_pf_i,
    input  logic below_bat_i,
    input  logic tick_i,
    input  logic test_clr_i,
    output logic access_block_o,
    output logic rst_drive_low_o,
    output logic src_backup_o,
    output logic bat_armed_o
);
    localparam int unsigned HOLD_RAW   = ceil_div(TICK_HZ * RECOVERY_MS, MS_PER_S);
    localparam int unsigned HOLD_TICKS = (HOLD_RAW > 0) ? HOLD_RAW : 1;

    logic recov_hold;

    sg_recovery_timer #(
        .HOLD_TICKS (HOLD_TICKS)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_low_i (below_pf_i),
        .tick_i       (tick_i),
        .hold_o       (recov_hold)
    );

    sg_backup_latch u_backup (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_low_i (below_pf_i),
        .below_bat_i  (below_bat_i),
        .test_clr_i   (test_clr_i),
        .armed_o      (bat_armed_o),
        .src_o        (src_backup_o)
    );

    always_comb begin
        access_block_o  = below_pf_i;
        rst_drive_low_o = below_pf_i | recov_hold;
    end

    a_r2_reset_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
        below_pf_i |-> rst_drive_low_o);

    a_r8_backup_only_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        src_backup_o |-> (access_block_o && bat_armed_o));

endmodule

// File: tb/sim_supply_guard.sv
`timescale 1ns/1ps
module sim_supply_guard;
    localparam int N = (32768 * 35 + 999) / 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic below_pf = 1'b1;
    logic below_bat = 1'b1;
    logic tick = 1'b0;
    logic tclr = 1'b0;
    logic blk, rstl, src, armed;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    supply_guard u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .below_pf_i      (below_pf),
        .below_bat_i     (below_bat),
        .tick_i          (tick),
        .test_clr_i      (tclr),
        .access_block_o  (blk),
        .rst_drive_low_o (rstl),
        .src_backup_o    (src),
        .bat_armed_o     (armed)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        @(negedge clk);
        #1;
        chk("R6", "reset drive", rstl, 1'b1);
        chk("R6", "armed", armed, 1'b0);
        chk("R6", "src", src, 1'b0);
        chk("R8", "unarmed no backup", src, 1'b0);
        chk("R1", "block while low", blk, 1'b1);
    endtask

    task automatic t_powerup;
        @(negedge clk);
        below_pf = 1'b0; below_bat = 1'b0; tick = 1'b1;
        #1;
        chk("R1", "block drops same cycle", blk, 1'b0);
        chk("R7", "not armed before edge", armed, 1'b0);
        edges(1);
        chk("R7", "armed after first good edge", armed, 1'b1);
        edges(N - 2);
        chk("R3", "held one edge early", rstl, 1'b1);
        edges(1);
        chk("R3", "released at HOLD_TICKS", rstl, 1'b0);
    endtask

    task automatic t_dip_restart;
        @(negedge clk);
        below_pf = 1'b1;
        #1;
        chk("R2", "reset same cycle as fail", rstl, 1'b1);
        chk("R1", "block same cycle as fail", blk, 1'b1);
        edges(3);
        chk("R2", "reset held while low", rstl, 1'b1);
        chk("R7", "armed kept through dip", armed, 1'b1);
        @(negedge clk);
        below_pf = 1'b0;
        edges(N / 2);
        chk("R3", "held mid recovery", rstl, 1'b1);
        @(negedge clk);
        below_pf = 1'b1;
        @(negedge clk);
        below_pf = 1'b0;
        edges(N - 1);
        chk("R4", "count restarted, still held", rstl, 1'b1);
        edges(1);
        chk("R4", "released after full restart", rstl, 1'b0);
    endtask

    task automatic t_no_tick;
        @(negedge clk);
        below_pf = 1'b1;
        @(negedge clk);
        below_pf = 1'b0; tick = 1'b0;
        edges(2 * N);
        chk("R5", "no ticks keeps reset", rstl, 1'b1);
        @(negedge clk);
        tick = 1'b1;
        edges(N - 1);
        chk("R5", "held before last tick", rstl, 1'b1);
        edges(1);
        chk("R5", "released after ticks", rstl, 1'b0);
    endtask

    task automatic t_switchover;
        @(negedge clk);
        below_pf = 1'b1; below_bat = 1'b0;
        #1;
        chk("R8", "above battery stays main", src, 1'b0);
        @(negedge clk);
        below_bat = 1'b1;
        #1;
        chk("R8", "below both selects backup", src, 1'b1);
        @(negedge clk);
        below_pf = 1'b0;
        #1;
        chk("R8", "supply good returns main", src, 1'b0);
        @(negedge clk);
        below_bat = 1'b0;
    endtask

    task automatic t_test_clear;
        @(negedge clk);
        tclr = 1'b1;
        edges(1);
        chk("R9", "clear beats arming", armed, 1'b0);
        @(negedge clk);
        tclr = 1'b0; below_pf = 1'b1; below_bat = 1'b1;
        #1;
        chk("R9", "cleared latch blocks backup", src, 1'b0);
        edges(1);
        chk("R9", "stays cleared while low", armed, 1'b0);
        @(negedge clk);
        below_pf = 1'b0; below_bat = 1'b0;
        edges(1);
        chk("R7", "rearmed on good supply", armed, 1'b1);
    endtask

    initial begin
        for (int c = 0; c < 200000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual expired expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        edges(3);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_powerup();
        t_dip_restart();
        t_no_tick();
        t_switchover();
        t_test_clear();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule